// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Address-Marker Bit

This block turns bytes into asynchronous serial frames on a single output line. The timing comes from an external bit-rate enable pulse, `bit_tick`. Each pulse marks the boundary of one bit period, and the block never counts clock cycles on its own. A byte is offered on a valid/ready handshake. On acceptance the block captures the byte together with the frame settings: parity on or off, even or odd parity, multiprocessor mode, and one or two stop bits. It then sends the start bit, the data bits, an optional extra bit and the stop bits. It does not offer a new byte until the last stop bit has finished.

In multiprocessor mode the extra bit after the data is an address marker rather than a parity bit. Its value comes from a per-byte input, so one unit can flag a byte as an address that is meant for listeners that only watch marked bytes, and send the bytes that follow unmarked. Parity is left out of the frame in this mode. Baud-rate generation and reception are handled elsewhere.

Top module: `async_mp_tx`

## Requirements
- R1: After reset, `tx_line` is 1 and `in_ready` is 1.
- R2: While no frame is in progress the line is 1. A frame's start bit (0) begins on the first `bit_tick` after the handshake, and every bit of the frame holds the line for exactly one tick interval.
- R3: The data bits follow the start bit, least significant bit first.
- R4: With parity on and multiprocessor mode off, one parity bit follows the data. When `cfg_par_odd`=0 the data bits and the parity bit together hold an even number of ones. When `cfg_par_odd`=1 they hold an odd number.
- R5: With parity off and multiprocessor mode off, the first stop bit follows the data directly, whatever the value of `cfg_par_odd`.
- R6: With `cfg_mp_en`=1, the bit after the data equals the `in_mark` value captured with the byte, and no parity bit is sent even when `cfg_par_en`=1.
- R7: The frame ends with stop bits at 1: one stop bit when `cfg_two_stop`=0 and two when it is 1.
- R8: `in_ready` falls in the cycle after a handshake and stays 0 until the tick that ends the final stop bit. It is 1 again in the following cycle.
- R9: The data, the marker and all configuration inputs are captured at the handshake. Changes to them during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be accepted |
| in_data | input | DATA_W | Byte to send |
| in_mark | input | 1 | Marker bit value for this byte |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cfg_mp_en | input | 1 | Multiprocessor (marker) mode |
| cfg_two_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| tx_line | output | 1 | Serial output |

## Verification
The hardest situations to reach from the ports are those where the tick stream runs into the handshake. One is a tick in the very cycle after a byte is accepted. Another is ticks on consecutive cycles, which shrink each bit to a single clock. A third is a byte waiting with valid high while the previous frame's last stop bit ends. The bench drives these with an irregular tick generator that switches between a fixed spacing, a tick every cycle and random spacing. It offers the next byte straight after each acceptance and scrambles the data and settings once each frame has been captured.

// File: rtl/async_mp_tx_pkg.sv
package async_mp_tx_pkg;

  // kind of optional bit placed between data and stop bits
  typedef enum logic [1:0] {
    XB_NONE   = 2'd0,
    XB_PARITY = 2'd1,
    XB_MARK   = 2'd2
  } extra_e;

  // marker mode takes precedence and suppresses parity
  function automatic extra_e pick_extra(logic par_en, logic mp_en);
    if (mp_en)  return XB_MARK;
    if (par_en) return XB_PARITY;
    return XB_NONE;
  endfunction

  // total number of bit periods of one frame
  function automatic int frame_len(int data_w, extra_e kind, logic two_stop);
    int n;
    n = 1 + data_w;
    if (kind != XB_NONE) n = n + 1;
    n = n + (two_stop ? 2 : 1);
    return n;
  endfunction

endpackage

// File: rtl/tx_frame_pack.sv
module tx_frame_pack
  import async_mp_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               mark_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               mp_en_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   len_o
);

  localparam int XPOS = DATA_W + 1;

  // parity: even -> xor of data, odd -> its inverse
  function automatic logic par_bit(logic [DATA_W-1:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  extra_e kind;

  always_comb begin
    kind              = pick_extra(par_en_i, mp_en_i);
    frame_o           = '1;            // idle/stop level fills the tail
    frame_o[0]        = 1'b0;          // start bit
    frame_o[DATA_W:1] = data_i;        // lsb sent first
    case (kind)
      XB_PARITY: frame_o[XPOS] = par_bit(data_i, par_odd_i);
      XB_MARK:   frame_o[XPOS] = mark_i;
      default:   frame_o[XPOS] = 1'b1; // first stop bit
    endcase
    len_o = CNT_W'(frame_len(DATA_W, kind, two_stop_i));
  end

endmodule

// File: rtl/tx_bit_engine.sv
module tx_bit_engine #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  output logic               ready_o,
  output logic               line_o
);

  logic               armed_q, busy_q;
  logic [CNT_W-1:0]   cnt_q, len_q;
  logic [FRAME_W-1:0] sh_q;

  // named internal events
  logic accept_evt, launch_evt, last_bit, shift_evt, done_evt;

  assign ready_o    = !armed_q && !busy_q;
  assign accept_evt = load_i && ready_o;
  assign launch_evt = armed_q && bit_tick;
  assign last_bit   = (cnt_q == len_q - CNT_W'(1));
  assign shift_evt  = busy_q && bit_tick && !last_bit;
  assign done_evt   = busy_q && bit_tick && last_bit;
  assign line_o     = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      sh_q    <= '1;
    end else if (accept_evt) begin
      armed_q <= 1'b1;
      sh_q    <= frame_i;
      len_q   <= len_i;
    end else if (launch_evt) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b1;
      cnt_q   <= '0;
    end else if (shift_evt) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (done_evt) begin
      busy_q <= 1'b0;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> line_o);                                        // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line_o);                                 // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_tick) |=> $stable(line_o));                 // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));                                // R7
  AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> line_o);                                       // R7
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ready_o);                                      // R8

endmodule

// File: rtl/async_mp_tx.sv
module async_mp_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_en,
  input  logic              cfg_two_stop,
  output logic              tx_line
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   len_w;

  tx_frame_pack #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_pack (
    .data_i     (in_data),
    .mark_i     (in_mark),
    .par_en_i   (cfg_par_en),
    .par_odd_i  (cfg_par_odd),
    .mp_en_i    (cfg_mp_en),
    .two_stop_i (cfg_two_stop),
    .frame_o    (frame_w),
    .len_o      (len_w)
  );

  tx_bit_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .load_i   (in_valid),
    .frame_i  (frame_w),
    .len_i    (len_w),
    .ready_o  (in_ready),
    .line_o   (tx_line)
  );

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);                      // R8

endmodule

// File: tb/test_async_mp_tx.sv
module test_async_mp_tx;

  localparam int DW = 8;
  localparam int R1_RESET = 1, R2_LINE = 2, R3_DATA = 3, R4_PARITY = 4,
                 R5_NOPAR = 5, R6_MARK = 6, R7_STOP = 7, R8_READY = 8;
  // data-bit checks also cover capture at handshake (R9)

  logic clk = 0, rst_n = 0, bit_tick = 0, in_valid = 0;
  logic in_mark = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_en = 0, cfg_two_stop = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, tx_line;

  int n_tests = 0, n_fail = 0;
  int tick_mode = 0, tick_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  async_mp_tx #(.DATA_W(DW)) i_async_mp_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_mark(in_mark),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en),
    .cfg_two_stop(cfg_two_stop), .tx_line(tx_line)
  );

  // ---------------- reference model ----------------
  logic qb[$];
  int   qt[$];
  bit   m_armed = 0, m_busy = 0, acc_seen = 0;

  task automatic push(logic b, int tag);
    qb.push_back(b); qt.push_back(tag);
  endtask

  task automatic build_frame();
    int ones = 0;
    qb.delete(); qt.delete();
    push(1'b0, R2_LINE);                          // start bit
    for (int i = 0; i < DW; i++) begin            // R3 lsb first
      push(in_data[i], R3_DATA);
      if (in_data[i]) ones++;
    end
    if (cfg_mp_en) push(in_mark, R6_MARK);        // R6 marker, no parity
    else if (cfg_par_en)                          // R4 even/odd count
      push(((ones % 2) == 1) != cfg_par_odd ? 1'b1 : 1'b0, R4_PARITY);
    push(1'b1, (!cfg_mp_en && !cfg_par_en) ? R5_NOPAR : R7_STOP);
    if (cfg_two_stop) push(1'b1, R7_STOP);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_busy = 0; qb.delete(); qt.delete();
    end else begin
      bit rdy;
      rdy = !m_armed && !m_busy;
      if (m_busy && bit_tick) begin
        void'(qb.pop_front()); void'(qt.pop_front());
        if (qb.size() == 0) m_busy = 0;
      end else if (m_armed && bit_tick) begin
        m_armed = 0; m_busy = 1;
      end
      if (rdy && in_valid) begin
        build_frame(); m_armed = 1; acc_seen = 1;
      end
    end
  end

  task automatic check(string what, int tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("tx_line", m_busy ? qt[0] : R2_LINE, tx_line, m_busy ? qb[0] : 1'b1);
      check("in_ready", R8_READY, in_ready, !m_armed && !m_busy);
    end
  end

  // ---------------- tick generator ----------------
  always @(negedge clk) begin
    case (tick_mode)
      0: begin tick_cnt = (tick_cnt + 1) % 4; bit_tick <= (tick_cnt == 0); end
      1: bit_tick <= 1'b1;
      default: bit_tick <= ($urandom % 3) == 0;
    endcase
  end

  // ---------------- stimulus ----------------
  task automatic send(logic [DW-1:0] d, logic mk, logic pe, logic po, logic mp, logic ts);
    @(negedge clk);
    in_data = d; in_mark = mk; cfg_par_en = pe; cfg_par_odd = po;
    cfg_mp_en = mp; cfg_two_stop = ts; in_valid = 1; acc_seen = 0;
    while (!acc_seen) @(negedge clk);
    in_valid = 0;
    in_data = ~d; in_mark = ~mk; cfg_par_en = ~pe; // R9 scramble after capture
    cfg_par_odd = ~po; cfg_mp_en = ~mp; cfg_two_stop = ~ts;
  endtask

  task automatic drain();
    while (m_armed || m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("reset tx_line", R1_RESET, tx_line, 1'b1);
    check("reset in_ready", R1_RESET, in_ready, 1'b1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R3/R7 plain frames
    send(8'hA5, 0, 0, 0, 0, 0);
    send(8'h01, 0, 0, 0, 0, 1);
    // R4 even and odd parity on edge patterns
    send(8'h00, 0, 1, 0, 0, 0);
    send(8'hFF, 0, 1, 0, 0, 0);
    send(8'h00, 0, 1, 1, 0, 1);
    send(8'h7F, 0, 1, 1, 0, 0);
    // R5 parity off, odd select has no effect
    send(8'h3C, 0, 0, 1, 0, 0);
    // R6 marker mode with parity enabled: marker replaces parity
    send(8'h55, 1, 1, 0, 1, 0);
    send(8'h55, 0, 1, 1, 1, 1);
    drain();
    tick_mode = 1;                      // a tick on every cycle
    send(8'hC3, 1, 0, 0, 1, 1);
    send(8'h81, 0, 1, 1, 0, 0);
    send(8'h18, 0, 0, 0, 0, 0);
    drain();
    tick_mode = 2;                      // irregular spacing
    for (int k = 0; k < 60; k++) begin
      send(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
      if (($urandom % 4) == 0) repeat ($urandom % 20) @(negedge clk);
    end
    drain();
    repeat (20) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule